// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit moves elements of one vector register under the control of a mask that holds one bit per element. In compress mode the elements whose mask bit is set are gathered and packed, in increasing source index order, into consecutive positions of the result starting at element 0. In expand mode the operation runs in reverse: the low source elements are taken in order, and each one goes to the position of the next set mask bit. Both modes report the packed length, which is the population count of the mask over the active elements.

A request is a single-cycle `start` pulse. It carries the operation select, the vector length, the mask, the source elements and the old destination contents. The unit copies the old destination into its result register. It then walks the active elements one per cycle, keeping a running pointer into the packed side. Result positions that no element is written to keep their old destination values. A one-cycle `done` pulse marks the point where `result` and `packed_len` are final. Both stay unchanged until the next accepted request.

The controller has three states. IDLE waits for `start`. On the accept transition it goes to RUN, or straight to FINISH when the vector length is 0. RUN processes one element per cycle. On its last-element transition it goes to FINISH. FINISH raises `done` for one cycle and returns to IDLE on its release transition.

Top module: `mask_permute_unit`

## Requirements
- R1: After reset, `done` and `busy` are 0, `packed_len` is 0 and every element of `result` is 0.
- R2: With `op`=0 (compress), the elements whose mask bit is 1 appear in `result` starting at element 0, in increasing source index order. Element k occupies bits [k*ELEM_W +: ELEM_W] of the flat vectors.
- R3: In compress, result elements at or above `packed_len` hold the old destination values.
- R4: With `op`=1 (expand), the k-th source element (counting from 0) is written to the position of the k-th set mask bit. Positions with a clear mask bit keep their old destination values.
- R5: When `done` is high, `packed_len` equals the number of set mask bits below the effective vector length, in both modes.
- R6: Mask bits at or above the vector length have no effect. A `vlen` greater than NUM_ELEM is treated as NUM_ELEM.
- R7: `done` is high for exactly one cycle. With the inputs driven before the edge that samples `start`, `done` is seen in the (L+1)-th cycle after that edge, where L is the effective vector length.
- R8: A `start` that arrives while `busy` is 1 is ignored. The running operation's result is unchanged, and no second `done` follows.
- R9: A mask that is all zero over the active elements, or a vector length of 0, gives `packed_len` 0 and a result equal to the old destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| op | input | 1 | 0 = compress, 1 = expand |
| vlen | input | LEN_W | Vector length for the request |
| mask | input | NUM_ELEM | One mask bit per element |
| src | input | NUM_ELEM*ELEM_W | Source elements, flat |
| old_dst | input | NUM_ELEM*ELEM_W | Prior destination contents, flat |
| result | output | NUM_ELEM*ELEM_W | Permuted destination, flat |
| packed_len | output | LEN_W | Number of elements packed or unpacked |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High from acceptance until done |

## Verification
The assertions assume that `start` is a clean synchronous level and that the request fields are valid in the cycle where `start` is sampled. After that cycle the unit works only from its latched copies, so later changes to the inputs cannot break the pointer and popcount properties. The stimulus changes inputs only on falling edges and holds `start` for one cycle per request. It also sends a deliberately conflicting request in the middle of a run, which checks that the latched copies shield the operation in progress.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    typedef enum logic {
        OP_COMPRESS = 1'b0,
        OP_EXPAND   = 1'b1
    } mpu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } mpu_state_e;

endpackage

// File: rtl/mpu_ctrl.sv
module mpu_ctrl
    import mpu_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    localparam int LEN_W   = $clog2(NUM_ELEM + 1),
    localparam int IDX_W   = $clog2(NUM_ELEM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] eff_len,
    output logic             load,
    output logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output logic             busy
);

    mpu_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic             last_elem;

    assign last_elem = ((LEN_W'(idx) + LEN_W'(1)) == len_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (eff_len == '0) ? ST_FINISH : ST_RUN;
                end
            end
            ST_RUN: begin
                if (last_elem) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        done = 1'b0;
        busy = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_RUN: begin
                step = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // element index and latched length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            len_q <= '0;
        end else if (load) begin
            idx   <= '0;
            len_q <= eff_len;
        end else if (step) begin
            idx   <= idx + IDX_W'(1);
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (LEN_W'(idx) < len_q));

    // R8
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last_elem) |=> step && (idx == $past(idx) + IDX_W'(1)));

    // R7
    finish_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/mpu_datapath.sv
module mpu_datapath
    import mpu_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int ELEM_W   = 16,
    localparam int LEN_W   = $clog2(NUM_ELEM + 1),
    localparam int IDX_W   = $clog2(NUM_ELEM),
    localparam int VEC_W   = NUM_ELEM * ELEM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [IDX_W-1:0] idx,
    input  logic             op_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic [NUM_ELEM-1:0] mask_in,
    input  logic [VEC_W-1:0] src_in,
    input  logic [VEC_W-1:0] old_in,
    output logic [VEC_W-1:0] result,
    output logic [LEN_W-1:0] packed_len
);

    logic [ELEM_W-1:0]   res_q [NUM_ELEM];
    logic [ELEM_W-1:0]   src_q [NUM_ELEM];
    logic [NUM_ELEM-1:0] mask_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    wptr_q;
    mpu_op_e             op_q;
    logic [IDX_W-1:0]    wsel;
    logic [NUM_ELEM-1:0] active_bits;

    assign wsel = wptr_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ELEM; i++) begin
                res_q[i] <= '0;
                src_q[i] <= '0;
            end
            mask_q <= '0;
            len_q  <= '0;
            wptr_q <= '0;
            op_q   <= OP_COMPRESS;
        end else if (load) begin
            for (int i = 0; i < NUM_ELEM; i++) begin
                res_q[i] <= old_in[i*ELEM_W +: ELEM_W];
                src_q[i] <= src_in[i*ELEM_W +: ELEM_W];
            end
            mask_q <= mask_in;
            len_q  <= len_in;
            wptr_q <= '0;
            op_q   <= mpu_op_e'(op_in);
        end else if (step && mask_q[idx]) begin
            if (op_q == OP_COMPRESS) begin
                res_q[wsel] <= src_q[idx];
            end else begin
                res_q[idx]  <= src_q[wsel];
            end
            wptr_q <= wptr_q + LEN_W'(1);
        end
    end

    generate
        for (genvar g = 0; g < NUM_ELEM; g++) begin : g_flat
            assign result[g*ELEM_W +: ELEM_W] = res_q[g];
        end
    endgenerate

    assign packed_len = wptr_q;

    // mask bits inside the latched length, for checking only
    always_comb begin
        for (int i = 0; i < NUM_ELEM; i++) begin
            active_bits[i] = mask_q[i] && (LEN_W'(i) < len_q);
        end
    end

    // R5
    popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load && $past(step)) |-> (packed_len == LEN_W'($countones(active_bits))));

    // R6
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        packed_len <= len_q);

    // R2
    ptr_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (wptr_q <= LEN_W'(idx)));

endmodule

// File: rtl/mask_permute_unit.sv
module mask_permute_unit #(
    parameter int NUM_ELEM = 8,
    parameter int ELEM_W   = 16,
    localparam int LEN_W   = $clog2(NUM_ELEM + 1),
    localparam int IDX_W   = $clog2(NUM_ELEM),
    localparam int VEC_W   = NUM_ELEM * ELEM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                op,
    input  logic [LEN_W-1:0]    vlen,
    input  logic [NUM_ELEM-1:0] mask,
    input  logic [VEC_W-1:0]    src,
    input  logic [VEC_W-1:0]    old_dst,
    output logic [VEC_W-1:0]    result,
    output logic [LEN_W-1:0]    packed_len,
    output logic                done,
    output logic                busy
);

    logic [LEN_W-1:0] eff_len;
    logic             load;
    logic             step;
    logic [IDX_W-1:0] idx;

    assign eff_len = (vlen > LEN_W'(NUM_ELEM)) ? LEN_W'(NUM_ELEM) : vlen;

    mpu_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .eff_len (eff_len),
        .load    (load),
        .step    (step),
        .idx     (idx),
        .done    (done),
        .busy    (busy)
    );

    mpu_datapath #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .idx        (idx),
        .op_in      (op),
        .len_in     (eff_len),
        .mask_in    (mask),
        .src_in     (src),
        .old_in     (old_dst),
        .result     (result),
        .packed_len (packed_len)
    );

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || $past(done)));

    // R9
    empty_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && eff_len == '0) |=> done && packed_len == '0);

endmodule

// File: tb/test_mask_permute_unit.sv
module test_mask_permute_unit;

    localparam int N  = 8;
    localparam int EW = 16;
    localparam int LW = 4;
    localparam int VW = N * EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op = 1'b0;
    logic [LW-1:0] vlen = '0;
    logic [N-1:0]  mask = '0;
    logic [VW-1:0] src = '0;
    logic [VW-1:0] old_dst = '0;
    logic [VW-1:0] result;
    logic [LW-1:0] packed_len;
    logic          done;
    logic          busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mask_permute_unit #(.NUM_ELEM(N), .ELEM_W(EW)) i_mask_permute_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vlen(vlen),
        .mask(mask), .src(src), .old_dst(old_dst), .result(result),
        .packed_len(packed_len), .done(done), .busy(busy)
    );

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic o, input logic [LW-1:0] l, input logic [N-1:0] m,
                         input logic [VW-1:0] s, input logic [VW-1:0] d,
                         output logic [VW-1:0] e, output logic [LW-1:0] pl);
        int eff;
        int w;
        eff = (l > N) ? N : int'(l);
        e = d;
        w = 0;
        for (int i = 0; i < eff; i++) begin
            if (m[i]) begin
                if (!o) e[w*EW +: EW] = s[i*EW +: EW];
                else    e[i*EW +: EW] = s[w*EW +: EW];
                w++;
            end
        end
        pl = LW'(w);
    endtask

    function automatic logic [VW-1:0] pattern(input logic [15:0] base);
        logic [VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*EW +: EW] = base + 16'(i);
        return v;
    endfunction

    task automatic run_op(input logic o, input logic [LW-1:0] l, input logic [N-1:0] m,
                          input logic [VW-1:0] s, input logic [VW-1:0] d, output int lat);
        @(negedge clk);
        op = o; vlen = l; mask = m; src = s; old_dst = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_case(input string tag, input logic o, input logic [LW-1:0] l,
                           input logic [N-1:0] m, input logic [VW-1:0] s, input logic [VW-1:0] d);
        logic [VW-1:0] e;
        logic [LW-1:0] pl;
        int lat;
        int eff;
        eff = (l > N) ? N : int'(l);
        model(o, l, m, s, d, e, pl);
        run_op(o, l, m, s, d, lat);
        chk({tag, " result"}, result, e);
        chk({tag, " packed_len R5"}, VW'(packed_len), VW'(pl));
        chk({tag, " latency R7"}, VW'(lat), VW'(eff + 1));
        @(negedge clk);
        chk({tag, " done pulse R7"}, VW'(done), '0);
        chk({tag, " result holds"}, result, e);
    endtask

    task automatic t_reset();
        chk("R1 done", VW'(done), '0);
        chk("R1 busy", VW'(busy), '0);
        chk("R1 packed_len", VW'(packed_len), '0);
        chk("R1 result", result, '0);
    endtask

    task automatic t_compress();
        do_case("R2 R3 compress mixed", 1'b0, 4'd8, 8'b1010_0110, pattern(16'h0100), pattern(16'hA000));
        do_case("R2 compress full", 1'b0, 4'd8, 8'hFF, pattern(16'h0200), pattern(16'hB000));
    endtask

    task automatic t_expand();
        do_case("R4 expand mixed", 1'b1, 4'd8, 8'b1100_1001, pattern(16'h0300), pattern(16'hC000));
        do_case("R4 expand full", 1'b1, 4'd8, 8'hFF, pattern(16'h0400), pattern(16'hD000));
    endtask

    task automatic t_length();
        do_case("R6 compress short vlen", 1'b0, 4'd5, 8'hFF, pattern(16'h0500), pattern(16'hE000));
        do_case("R6 expand short vlen", 1'b1, 4'd3, 8'b1111_0101, pattern(16'h0600), pattern(16'hF000));
        do_case("R6 vlen clamp", 1'b0, 4'd15, 8'hF0, pattern(16'h0700), pattern(16'h1000));
    endtask

    task automatic t_empty();
        do_case("R9 compress zero mask", 1'b0, 4'd8, 8'h00, pattern(16'h0800), pattern(16'h2000));
        do_case("R9 expand zero mask", 1'b1, 4'd6, 8'hC0, pattern(16'h0900), pattern(16'h3000));
        do_case("R9 zero vlen", 1'b0, 4'd0, 8'hFF, pattern(16'h0A00), pattern(16'h4000));
    endtask

    task automatic t_busy();
        logic [VW-1:0] e;
        logic [LW-1:0] pl;
        int lat;
        int seen;
        model(1'b0, 4'd8, 8'b0101_1010, pattern(16'h0B00), pattern(16'h5000), e, pl);
        @(negedge clk);
        op = 1'b0; vlen = 4'd8; mask = 8'b0101_1010;
        src = pattern(16'h0B00); old_dst = pattern(16'h5000); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        op = 1'b1; vlen = 4'd2; mask = 8'hFF; src = pattern(16'h7700); old_dst = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 4;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 result after ignored start", result, e);
        chk("R8 packed_len after ignored start", VW'(packed_len), VW'(pl));
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk("R8 no second done", VW'(seen), '0);
        chk("R8 idle after run", VW'(busy), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_compress();
        t_expand();
        t_length();
        t_empty();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule